// File: doc/BRIEF.md
# Tester Pin Scan-Chain Array

This block is the digital core of a tester's pin electronics. It controls a set of device-under-test pins, 64 by default. Each pin has an enable bit and a data bit. Test vectors enter bit by bit through a serial chain of two bits per pin. The chain is moved by two phase enables, `ph1_i` and `ph2_i`, which must never be high in the same cycle, on a single system clock. A drive strobe copies the whole chain into hold registers at once. Those registers set each pin's three-state driver, so the pins stay steady while the next vector is shifted in.

A sample strobe reads the pins in the other direction. It loads every pin's input level into that pin's data slot in the chain, and the result is then shifted out serially. While sample is high, the serial output shows a free-running test oscillator instead of chain data.

Level conversion, comparators and pads are outside this block. The pins are modelled as an output-enable vector, an output-data vector and an input-level vector.

Top module: `pin_scan_array`

## Requirements
- R1: While `rst_ni` is low, every pin is undriven (`pin_oe_o` = 0, `pin_out_o` = 0), `sdout_o` is 0 and `phase_err_o` is 0.
- R2: After 128 shift pairs followed by a drive, the 1st bit shifted in is the enable of pin 63 and the 2nd is its data. In general, the bit shifted in at position k (counting from 0) is the enable of pin p when k = 126-2p and the data of pin p when k = 127-2p.
- R3: A pin whose held enable is 1 has `pin_oe_o` = 1 and `pin_out_o` equal to its held data. A pin whose held enable is 0 has `pin_oe_o` = 0 and `pin_out_o` = 0.
- R4: A cycle with `ph2_i` = 1 and `drive_i` = 1 copies every enable and data bit into the hold registers together, and the pins show them from the next cycle. In every other cycle the pins keep their values, including while the chain shifts.
- R5: A `ph2_i` cycle with `drive_i` high does not move the chain. A `ph1_i` cycle with `sample_i` high does not shift the chain.
- R6: A `ph1_i` cycle with `sample_i` high loads `pin_in_i[p]` into the data slot of pin p and leaves its enable slot unchanged. The following scan-out then shows the sampled levels at positions 127-2p.
- R7: While `sample_i` is high, `sdout_o` shows the test oscillator. The oscillator is held at 0 while sample is low and toggles on every clock while sample is high. When sample is low, `sdout_o` shows the last chain bit.
- R8: A cycle with both `ph1_i` and `ph2_i` high changes neither the chain nor the pins, and `phase_err_o` is 1 for exactly the following cycle.
- R9: The chain moves exactly one bit per `ph2_i`/`ph1_i` pair. A vector loaded by 128 pairs reappears on `sdout_o` in the order it was shifted in.
- R10: Repeated `ph2_i` cycles without a `ph1_i` between them advance the chain by only one position. The bit that enters is the `sdin_i` value of the last `ph2_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ph1_i | input | 1 | Phase-1 enable: chain transfer or sample capture |
| ph2_i | input | 1 | Phase-2 enable: serial input or drive |
| drive_i | input | 1 | Drive strobe, acts on a ph2 cycle |
| sample_i | input | 1 | Sample strobe, acts on a ph1 cycle; selects the oscillator on sdout |
| sdin_i | input | 1 | Serial scan input |
| sdout_o | output | 1 | Serial scan output, or the oscillator while sample is high |
| pin_in_i | input | NUM_PINS | Logic level read from each device pin |
| pin_oe_o | output | NUM_PINS | Per-pin driver enable |
| pin_out_o | output | NUM_PINS | Per-pin drive value (0 when undriven) |
| phase_err_o | output | 1 | Set for one cycle after a cycle with both phases high |

## Verification
The in-RTL assertions check on every cycle that no two phase operations fire together and that a phase clash raises the error flag. They also check that the hold registers load only on a drive strobe and otherwise stay still, that a sample capture takes the pin level while keeping the enable slot, that an idle cell does not change, and that the oscillator toggles while sample is high. Only the bench scenarios can show the global properties: the bit-order mapping from serial position to pin, complete round trips of a vector through 128 shift pairs, the pins holding steady over a full reload, and the single-step advance after repeated ph2 cycles.

// File: rtl/pin_scan_pkg.sv
package pin_scan_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_LATCH_IN,
    OP_DRIVE,
    OP_PASS,
    OP_CAPTURE,
    OP_CLASH
  } phase_op_e;
endpackage

// File: rtl/phase_decode.sv
module phase_decode
  import pin_scan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph1_i,
  input  logic ph2_i,
  input  logic drive_i,
  input  logic sample_i,
  output logic shift_m_o,
  output logic load_hold_o,
  output logic xfer_o,
  output logic capture_o,
  output logic clash_o
);
  phase_op_e op;
  logic      clash_q;

  always_comb begin
    unique case ({ph1_i, ph2_i})
      2'b01:   op = drive_i  ? OP_DRIVE   : OP_LATCH_IN;
      2'b10:   op = sample_i ? OP_CAPTURE : OP_PASS;
      2'b11:   op = OP_CLASH;
      default: op = OP_IDLE;
    endcase
  end

  assign shift_m_o   = (op == OP_LATCH_IN);
  assign load_hold_o = (op == OP_DRIVE);
  assign xfer_o      = (op == OP_PASS);
  assign capture_o   = (op == OP_CAPTURE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clash_q <= 1'b0;
    else         clash_q <= (op == OP_CLASH);
  end
  assign clash_o = clash_q;

  p_one_op_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({shift_m_o, load_hold_o, xfer_o, capture_o}));
  p_clash_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph1_i && ph2_i) |=> clash_o);
  p_clash_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph1_i && ph2_i) |=> !clash_o);
endmodule

// File: rtl/scan_pin_cell.sv
module scan_pin_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_m_i,
  input  logic xfer_i,
  input  logic capture_i,
  input  logic load_hold_i,
  input  logic scan_i,
  input  logic pin_in_i,
  output logic scan_o,
  output logic oe_o,
  output logic out_o
);
  // master/slave pairs: data slot first on the chain, enable slot second
  logic m_d, m_en, s_d, s_en, h_d, h_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_d  <= 1'b0;
      m_en <= 1'b0;
    end else if (shift_m_i) begin
      m_d  <= scan_i;
      m_en <= s_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_d  <= 1'b0;
      s_en <= 1'b0;
    end else if (xfer_i) begin
      s_d  <= m_d;
      s_en <= m_en;
    end else if (capture_i) begin
      s_d  <= pin_in_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_d  <= 1'b0;
      h_en <= 1'b0;
    end else if (load_hold_i) begin
      h_d  <= s_d;
      h_en <= s_en;
    end
  end

  assign scan_o = s_en;
  assign oe_o   = h_en;
  assign out_o  = h_en & h_d;

  p_hold_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_hold_i |=> (h_en == $past(s_en) && h_d == $past(s_d)));
  p_hold_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_hold_i |=> $stable({h_en, h_d}));
  p_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (s_d == $past(pin_in_i) && s_en == $past(s_en)));
  p_idle_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_m_i && !xfer_i && !capture_i) |=> $stable({m_d, m_en, s_d, s_en}));
endmodule

// File: rtl/test_osc.sv
module test_osc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic osc_o
);
  logic osc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    osc_q <= 1'b0;
    else if (run_i) osc_q <= ~osc_q;
    else            osc_q <= 1'b0;
  end
  assign osc_o = osc_q;

  p_osc_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (osc_o != $past(osc_o)));
  p_osc_park_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !osc_o);
endmodule

// File: rtl/pin_scan_array.sv
module pin_scan_array #(
  parameter int NUM_PINS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ph1_i,
  input  logic                ph2_i,
  input  logic                drive_i,
  input  logic                sample_i,
  input  logic                sdin_i,
  output logic                sdout_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic                phase_err_o
);
  logic              shift_m, load_hold, xfer, capture;
  logic              osc;
  logic [NUM_PINS:0] link;

  phase_decode u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ph1_i      (ph1_i),
    .ph2_i      (ph2_i),
    .drive_i    (drive_i),
    .sample_i   (sample_i),
    .shift_m_o  (shift_m),
    .load_hold_o(load_hold),
    .xfer_o     (xfer),
    .capture_o  (capture),
    .clash_o    (phase_err_o)
  );

  assign link[0] = sdin_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    scan_pin_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_m_i  (shift_m),
      .xfer_i     (xfer),
      .capture_i  (capture),
      .load_hold_i(load_hold),
      .scan_i     (link[p]),
      .pin_in_i   (pin_in_i[p]),
      .scan_o     (link[p+1]),
      .oe_o       (pin_oe_o[p]),
      .out_o      (pin_out_o[p])
    );
  end

  test_osc u_osc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (sample_i),
    .osc_o (osc)
  );

  assign sdout_o = sample_i ? osc : link[NUM_PINS];

  p_pins_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph2_i && drive_i && !ph1_i) |=> $stable({pin_oe_o, pin_out_o}));
endmodule

// File: tb/pin_scan_array_bench.sv
module pin_scan_array_bench;
  localparam int NP = 64;
  localparam int CL = 2 * NP;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ph1 = 0, ph2 = 0, drive = 0, sample = 0, sdin = 0;
  logic sdout, perr;
  logic [NP-1:0] pin_in = '0, oe, pout;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pin_scan_array #(.NUM_PINS(NP)) u_pin_scan_array (
    .clk_i(clk), .rst_ni(rst_ni), .ph1_i(ph1), .ph2_i(ph2), .drive_i(drive),
    .sample_i(sample), .sdin_i(sdin), .sdout_o(sdout), .pin_in_i(pin_in),
    .pin_oe_o(oe), .pin_out_o(pout), .phase_err_o(perr)
  );

  task automatic chk(string tag, logic [CL-1:0] act, logic [CL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic p1, logic p2, logic drv, logic smp, logic din);
    @(negedge clk);
    ph1 = p1; ph2 = p2; drive = drv; sample = smp; sdin = din;
    @(posedge clk);
    #1;
  endtask

  task automatic pair(logic b);
    cyc(0, 1, 0, 0, b);
    cyc(1, 0, 0, 0, 0);
  endtask

  task automatic load(logic [CL-1:0] v);
    for (int k = 0; k < CL; k++) pair(v[k]);
  endtask

  task automatic read_stream(output logic [CL-1:0] got);
    for (int j = 0; j < CL; j++) begin
      got[j] = sdout;
      pair(1'b0);
    end
  endtask

  function automatic logic [NP-1:0] en_of(logic [CL-1:0] v);
    for (int p = 0; p < NP; p++) en_of[p] = v[126-2*p];
  endfunction
  function automatic logic [NP-1:0] dat_of(logic [CL-1:0] v);
    for (int p = 0; p < NP; p++) dat_of[p] = v[127-2*p];
  endfunction

  localparam logic [CL-1:0] VEC_A = {4{32'h5A3C_F169}};
  localparam logic [CL-1:0] VEC_B = {32'h0F0F_A5A5, 32'h1234_8765, 32'hFFFF_0000, 32'hC3C3_9696};

  task automatic t_reset();
    @(negedge clk);
    chk("R1 oe", CL'(oe), '0);
    chk("R1 out", CL'(pout), '0);
    chk("R1 sdout/err", CL'({sdout, perr}), '0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_load_drive();
    load(VEC_A);
    cyc(0, 1, 1, 0, 0);
    chk("R2 enable order", CL'(oe), CL'(en_of(VEC_A)));
    chk("R3 drive value", CL'(pout), CL'(en_of(VEC_A) & dat_of(VEC_A)));
    chk("R3 undriven low", CL'(pout & ~oe), '0);
  endtask

  task automatic t_hold_during_shift();
    int bad = 0;
    for (int k = 0; k < CL; k++) begin
      pair(VEC_B[k]);
      if (oe !== en_of(VEC_A) || pout !== (en_of(VEC_A) & dat_of(VEC_A))) bad++;
    end
    chk("R4 pins steady while shifting", CL'(bad), '0);
    cyc(0, 1, 1, 0, 0);
    chk("R4 simultaneous update oe", CL'(oe), CL'(en_of(VEC_B)));
    chk("R2 data order", CL'(pout), CL'(en_of(VEC_B) & dat_of(VEC_B)));
  endtask

  task automatic t_stream();
    logic [CL-1:0] got;
    read_stream(got);
    chk("R9 round trip", got, VEC_B);
  endtask

  task automatic t_double_ph2();
    logic [CL-1:0] got, exp;
    load(VEC_B);
    cyc(0, 1, 0, 0, 1);
    cyc(0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    read_stream(got);
    exp = {1'b0, VEC_B[CL-1:1]};
    chk("R10 single advance", got, exp);
  endtask

  task automatic t_drive_no_shift();
    logic [CL-1:0] got;
    load(VEC_A);
    cyc(0, 1, 1, 0, 1);
    cyc(1, 0, 0, 0, 0);
    read_stream(got);
    chk("R5 drive does not shift", got, VEC_A);
  endtask

  task automatic t_osc();
    logic [CL-1:0] seq;
    load(VEC_A);
    seq = '0;
    for (int n = 0; n < 4; n++) begin
      cyc(0, 0, 0, 1, 0);
      seq[n] = sdout;
    end
    chk("R7 osc toggles", seq, CL'(4'b0101));
    cyc(0, 0, 0, 0, 0);
    chk("R7 chain after sample", CL'(sdout), CL'(VEC_A[0]));
  endtask

  task automatic t_clash();
    logic [NP-1:0] oe0, out0;
    oe0 = oe; out0 = pout;
    cyc(1, 1, 1, 0, 1);
    chk("R8 err raised", CL'(perr), CL'(1));
    chk("R8 pins unchanged", CL'({oe, pout}), CL'({oe0, out0}));
    chk("R8 sdout unchanged", CL'(sdout), CL'(VEC_A[0]));
    cyc(0, 0, 0, 0, 0);
    chk("R8 err one cycle", CL'(perr), CL'(0));
    cyc(0, 1, 1, 0, 0);
    chk("R8 chain intact", CL'(oe), CL'(en_of(VEC_A)));
  endtask

  task automatic t_sample();
    logic [CL-1:0] got, exp;
    logic [NP-1:0] lv;
    lv = 64'h9E37_79B9_7F4A_7C15;
    load(VEC_B);
    pin_in = lv;
    cyc(1, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    pin_in = '0;
    read_stream(got);
    exp = VEC_B;
    for (int p = 0; p < NP; p++) exp[127-2*p] = lv[p];
    chk("R6 sampled stream", got, exp);
    chk("R5 sample no shift enables", CL'(en_of(got)), CL'(en_of(VEC_B)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_load_drive();
    t_hold_during_shift();
    t_stream();
    t_double_ph2();
    t_drive_no_shift();
    t_osc();
    t_clash();
    t_sample();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule